// File: doc/BRIEF.md
# Dual-Clock Line Delay Memory

This block is a sequential line store for delaying a stream of words, such as video lines, by a programmable number of sample periods. It has a write side and a read side, and each side has its own clock. Each side also has an active-low enable and an active-low pointer clear. Each side keeps its own address counter, which steps through a fixed line of `DEPTH` words and wraps back to zero. The block has no occupancy flags and never compares the two pointers.

The caller sets the delay. Clearing both pointers on the same edge with both enables low gives a delay of exactly one line. Clearing the read pointer n edges after the write pointer gives a delay of n. Holding the read enable high for n edges after a joint clear also gives a delay of n.

The read data comes from a registered output. The data pins are released to high impedance whenever the previous read edge did not perform a read. The output-enable that drives the pins is also brought out on a port. Each clock domain has its own synchronous active-high reset, which clears that domain's pointer and, on the read side, the output enable.

Top module: `line_delay_mem`

## Requirements
- R1: A rising `wr_clk` edge with `wr_en_n` low and `wr_clr_n` high stores `wr_data` at the write address, and the write address then advances by one.
- R2: A rising `wr_clk` edge with `wr_en_n` high and `wr_clr_n` high stores nothing, and the write address holds.
- R3: A rising `wr_clk` edge with `wr_clr_n` low sets the write address to 0 and stores nothing, whatever the level of `wr_en_n`. The next enabled write lands at word 0.
- R4: A rising `rd_clk` edge with `rd_en_n` low and `rd_clr_n` high loads the word at the read address into the output register. The read address then advances. After that edge `rd_oe` is 1 and `rd_q` carries the word.
- R5: A rising `rd_clk` edge with `rd_en_n` high and `rd_clr_n` high leaves the read address unchanged. After that edge `rd_oe` is 0 and `rd_q` is high impedance.
- R6: A rising `rd_clk` edge with `rd_clr_n` low sets the read address to 0 and performs no read, whatever the level of `rd_en_n`. `rd_oe` is 0 after it, and the next enabled read returns word 0.
- R7: Both address counters wrap from `DEPTH-1` to 0 on an advancing edge.
- R8: If a read and a write address the same word on coincident edges, the read returns the word's previous content. Clearing both pointers on one edge with both enables low therefore delays every word by exactly `DEPTH` edges.
- R9: A delay of n edges, with n below `DEPTH`, results from either of two controls, with both enables otherwise low. One is clearing the read pointer n edges after the write pointer. The other is holding `rd_en_n` high for the n edges that follow a joint clear.
- R10: While `wr_rst` is high the write address is 0. While `rd_rst` is high the read address is 0 and `rd_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Write-side synchronous reset, active high |
| wr_en_n | input | 1 | Write enable, active low |
| wr_clr_n | input | 1 | Write pointer clear, active low |
| wr_data | input | W | Word to store |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Read-side synchronous reset, active high |
| rd_en_n | input | 1 | Read enable, active low |
| rd_clr_n | input | 1 | Read pointer clear, active low |
| rd_q | output | W | Read data, high impedance when not driving |
| rd_oe | output | 1 | High while `rd_q` is being driven |

## Verification
The main collision is a read and a write of the same word on coincident edges. The bench runs both clocks in phase and clears both pointers on one edge. Each word must then reappear exactly `DEPTH` edges after it was written, which requires the read to return the old content. A second collision is a pointer clear arriving on the same edge as an active enable on the same side. For both the write and the read side, the bench checks that the clear wins and that nothing is stored or read on that edge. All results are compared, on every edge, against a behavioural model and against a history of the words written.

// File: rtl/ldm_pkg.sv
`timescale 1ns/1ps
package ldm_pkg;
  // Action an address counter takes on one edge of its clock.
  typedef enum logic [1:0] {
    PTR_HOLD  = 2'd0,
    PTR_STEP  = 2'd1,
    PTR_CLEAR = 2'd2
  } ptr_op_e;
endpackage

// File: rtl/ldm_ptr.sv
`timescale 1ns/1ps
// Wrapping address counter for one side of the line memory.
module ldm_ptr #(
  parameter int DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr_n,
  input  logic                     en_n,
  output logic [$clog2(DEPTH)-1:0] addr,
  output logic                     fire
);
  import ldm_pkg::*;

  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  ptr_op_e op;

  // A clear outranks the enable on the same edge.
  always_comb begin
    if (!clr_n)     op = PTR_CLEAR;
    else if (!en_n) op = PTR_STEP;
    else            op = PTR_HOLD;
  end

  assign fire = (op == PTR_STEP) && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else begin
      case (op)
        PTR_CLEAR: addr <= '0;
        PTR_STEP:  addr <= (addr == LAST) ? '0 : addr + 1'b1;
        default:   addr <= addr;
      endcase
    end
  end
endmodule

// File: rtl/ldm_ram.sv
`timescale 1ns/1ps
// Simple dual-port storage with a registered read port, written so that
// a dual-clock block RAM can be inferred.
module ldm_ram #(
  parameter int DEPTH = 1024,
  parameter int W     = 8
) (
  input  logic                     wr_clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic                     rd_clk,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ldm_rd_out.sv
`timescale 1ns/1ps
// Output-enable register and pin driver for the read data.
module ldm_rd_out #(
  parameter int W = 8
) (
  input  logic         rd_clk,
  input  logic         rd_rst,
  input  logic         fire,
  input  logic [W-1:0] rdata,
  output logic [W-1:0] rd_q,
  output logic         rd_oe
);
  always_ff @(posedge rd_clk) begin
    if (rd_rst) rd_oe <= 1'b0;
    else        rd_oe <= fire;
  end

  assign rd_q = rd_oe ? rdata : {W{1'bz}};
endmodule

// File: rtl/line_delay_mem.sv
`timescale 1ns/1ps
module line_delay_mem #(
  parameter int DEPTH = 1024,
  parameter int W     = 8
) (
  input  logic         wr_clk,
  input  logic         wr_rst,
  input  logic         wr_en_n,
  input  logic         wr_clr_n,
  input  logic [W-1:0] wr_data,
  input  logic         rd_clk,
  input  logic         rd_rst,
  input  logic         rd_en_n,
  input  logic         rd_clr_n,
  output logic [W-1:0] rd_q,
  output logic         rd_oe
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_fire;
  logic              rd_fire;
  logic [W-1:0]      rd_word;

  ldm_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
    .clk   (wr_clk),
    .rst   (wr_rst),
    .clr_n (wr_clr_n),
    .en_n  (wr_en_n),
    .addr  (wr_addr),
    .fire  (wr_fire)
  );

  ldm_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
    .clk   (rd_clk),
    .rst   (rd_rst),
    .clr_n (rd_clr_n),
    .en_n  (rd_en_n),
    .addr  (rd_addr),
    .fire  (rd_fire)
  );

  ldm_ram #(.DEPTH(DEPTH), .W(W)) u_ram (
    .wr_clk (wr_clk),
    .we     (wr_fire),
    .waddr  (wr_addr),
    .wdata  (wr_data),
    .rd_clk (rd_clk),
    .re     (rd_fire),
    .raddr  (rd_addr),
    .rdata  (rd_word)
  );

  ldm_rd_out #(.W(W)) u_out (
    .rd_clk (rd_clk),
    .rd_rst (rd_rst),
    .fire   (rd_fire),
    .rdata  (rd_word),
    .rd_q   (rd_q),
    .rd_oe  (rd_oe)
  );
endmodule

// File: rtl/ldm_chk.sv
`timescale 1ns/1ps
module ldm_chk #(
  parameter int DEPTH = 1024
) (
  input logic                     wr_clk,
  input logic                     wr_rst,
  input logic                     wr_en_n,
  input logic                     wr_clr_n,
  input logic                     rd_clk,
  input logic                     rd_rst,
  input logic                     rd_en_n,
  input logic                     rd_clr_n,
  input logic                     rd_oe,
  input logic [$clog2(DEPTH)-1:0] wr_addr,
  input logic [$clog2(DEPTH)-1:0] rd_addr
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  assert_wr_step_R1: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_clr_n && !wr_en_n && wr_addr != LAST) |=> wr_addr == ADDR_W'($past(wr_addr) + 1'b1));

  assert_wr_hold_R2: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_clr_n && wr_en_n) |=> $stable(wr_addr));

  assert_wr_clear_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !wr_clr_n |=> wr_addr == '0);

  assert_rd_drive_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_clr_n && !rd_en_n) |=> rd_oe);

  assert_rd_idle_R5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_clr_n && rd_en_n) |=> (!rd_oe && $stable(rd_addr)));

  assert_rd_clear_R6: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_clr_n |=> (rd_addr == '0 && !rd_oe));

  assert_wr_wrap_R7: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_clr_n && !wr_en_n && wr_addr == LAST) |=> wr_addr == '0);

  assert_rd_wrap_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_clr_n && !rd_en_n && rd_addr == LAST) |=> rd_addr == '0);

  assert_wr_reset_R10: assert property (@(posedge wr_clk)
    wr_rst |=> wr_addr == '0);

  assert_rd_reset_R10: assert property (@(posedge rd_clk)
    rd_rst |=> (rd_addr == '0 && !rd_oe));
endmodule

bind line_delay_mem ldm_chk #(.DEPTH(DEPTH)) u_chk (
  .wr_clk   (wr_clk),
  .wr_rst   (wr_rst),
  .wr_en_n  (wr_en_n),
  .wr_clr_n (wr_clr_n),
  .rd_clk   (rd_clk),
  .rd_rst   (rd_rst),
  .rd_en_n  (rd_en_n),
  .rd_clr_n (rd_clr_n),
  .rd_oe    (rd_oe),
  .wr_addr  (wr_addr),
  .rd_addr  (rd_addr)
);

// File: tb/line_delay_mem_tb.sv
`timescale 1ns/1ps
module line_delay_mem_tb;
  localparam int DEPTH = 64;
  localparam int W     = 8;
  localparam int NDLY  = 20;

  logic         wr_clk = 1'b0;
  logic         rd_clk = 1'b0;
  logic         wr_rst, wr_en_n, wr_clr_n;
  logic [W-1:0] wr_data;
  logic         rd_rst, rd_en_n, rd_clr_n;
  wire  [W-1:0] rd_q;
  logic         rd_oe;

  always #2.5 begin
    wr_clk = ~wr_clk;
    rd_clk = ~rd_clk;
  end

  line_delay_mem #(.DEPTH(DEPTH), .W(W)) u_dut (
    .wr_clk (wr_clk), .wr_rst (wr_rst), .wr_en_n (wr_en_n),
    .wr_clr_n (wr_clr_n), .wr_data (wr_data),
    .rd_clk (rd_clk), .rd_rst (rd_rst), .rd_en_n (rd_en_n),
    .rd_clr_n (rd_clr_n), .rd_q (rd_q), .rd_oe (rd_oe)
  );

  // Behavioural reference
  logic [W-1:0] m_mem [DEPTH];
  bit           m_known [DEPTH];
  int           wp, rp;
  bit           e_oe, e_qv;
  logic [W-1:0] e_q;
  logic [W-1:0] hist [4096];
  int           edge_n;
  int           checks, errors;
  bit           done;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (edge %0d)", r, act, exp, edge_n);
    end
  endtask

  // One edge: update the model from the inputs present at the edge,
  // then compare the outputs 1 ns after it.
  task automatic cyc(string r);
    @(posedge wr_clk);
    if (rd_rst || !rd_clr_n) begin
      rp = 0; e_oe = 0;
    end else if (!rd_en_n) begin
      e_q = m_mem[rp]; e_qv = m_known[rp]; e_oe = 1; rp = (rp + 1) % DEPTH;
    end else begin
      e_oe = 0;
    end
    if (wr_rst || !wr_clr_n) begin
      wp = 0;
    end else if (!wr_en_n) begin
      m_mem[wp] = wr_data; m_known[wp] = 1; wp = (wp + 1) % DEPTH;
    end
    hist[edge_n] = wr_data;
    edge_n++;
    #1;
    chk(r, {31'd0, rd_oe}, {31'd0, e_oe});
    if (e_oe && e_qv) chk(r, {24'd0, rd_q}, {24'd0, e_q});
  endtask

  task automatic drv(logic wen, logic wclr, logic [W-1:0] d, logic ren, logic rclr);
    wr_en_n = wen; wr_clr_n = wclr; wr_data = d; rd_en_n = ren; rd_clr_n = rclr;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int mark;
    checks = 0; errors = 0; edge_n = 0; done = 0;
    wp = 0; rp = 0; e_oe = 0; e_qv = 0; e_q = '0;
    for (int i = 0; i < DEPTH; i++) m_known[i] = 0;
    wr_rst = 1; rd_rst = 1;
    drv(1, 1, 8'h00, 1, 1);
    repeat (3) cyc("R10");
    chk("R10", {31'd0, rd_oe}, 32'd0);
    wr_rst = 0; rd_rst = 0;

    // Fill one line while reading is off: R1 writes, R5 pins released.
    for (int i = 0; i < DEPTH; i++) begin
      drv(0, 1, W'(i * 5 + 1), 1, 1);
      cyc("R5");
    end
    // Writes disabled with a marker value: must not land (R2).
    for (int i = 0; i < 4; i++) begin
      drv(1, 1, 8'hEE, 1, 1);
      cyc("R2");
    end
    // Read clear then a full line plus wrap (R6, R4, R7).
    drv(1, 1, 8'h00, 0, 0);
    cyc("R6");
    drv(1, 1, 8'h00, 0, 1);
    cyc("R4");
    chk("R2", {24'd0, rd_q}, 32'h01);
    for (int i = 1; i < DEPTH + 3; i++) cyc("R7");
    // Read pauses mid-stream: counter holds (R5).
    drv(1, 1, 8'h00, 1, 1);
    repeat (3) cyc("R5");
    drv(1, 1, 8'h00, 0, 1);
    repeat (4) cyc("R5");

    // Write clear with enable low stores nothing (R3).
    drv(0, 0, 8'hAA, 1, 1);
    cyc("R3");
    drv(0, 1, 8'h11, 1, 1);
    cyc("R3");
    drv(0, 1, 8'h22, 1, 1);
    cyc("R3");
    drv(1, 1, 8'h00, 0, 0);
    cyc("R6");
    drv(1, 1, 8'h00, 0, 1);
    cyc("R3");
    chk("R3", {24'd0, rd_q}, 32'h11);
    cyc("R3");
    chk("R3", {24'd0, rd_q}, 32'h22);

    // Joint clear: one full line of delay (R8).
    drv(0, 0, 8'h00, 0, 0);
    cyc("R8");
    mark = edge_n - 1;
    for (int j = 1; j <= 2 * DEPTH + 4; j++) begin
      drv(0, 1, W'(edge_n * 13 + 7), 0, 1);
      cyc("R8");
      if (j > DEPTH) chk("R8", {24'd0, rd_q}, {24'd0, hist[edge_n - 1 - DEPTH]});
    end

    // Delay by offset clears (R9).
    drv(0, 0, W'(edge_n * 3), 0, 1);
    cyc("R9");
    for (int j = 1; j < NDLY; j++) begin
      drv(0, 1, W'(edge_n * 3), 0, 1);
      cyc("R9");
    end
    drv(0, 1, W'(edge_n * 3), 0, 0);
    cyc("R9");
    for (int j = 1; j <= 2 * NDLY; j++) begin
      drv(0, 1, W'(edge_n * 3 + 5), 0, 1);
      cyc("R9");
      chk("R9", {24'd0, rd_q}, {24'd0, hist[edge_n - 1 - NDLY]});
    end

    // Delay by holding the read enable off after a joint clear (R9).
    drv(0, 0, W'(edge_n * 11), 0, 0);
    cyc("R9");
    for (int j = 1; j <= NDLY; j++) begin
      drv(0, 1, W'(edge_n * 11), 1, 1);
      cyc("R9");
    end
    for (int j = 1; j <= 2 * NDLY; j++) begin
      drv(0, 1, W'(edge_n * 11 + 2), 0, 1);
      cyc("R9");
      chk("R9", {24'd0, rd_q}, {24'd0, hist[edge_n - 1 - NDLY]});
    end
    if (mark < 0) $display("unreachable");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule